// File: doc/BRIEF.md
# Two-Wire Control Register Bank Slave

This block is a two-wire serial bus slave that gives a bus controller access to a small bank of byte-wide control registers. The block samples SCL and SDA with the system clock. It detects start and stop conditions, shifts bytes in and out, and pulls SDA low to acknowledge a byte. The current register contents are always visible as a flat output vector, so that the surrounding logic can use them directly.

There is no sub-address. Every write carries two filler bytes after the address byte. The slave acknowledges both filler bytes and then discards them. Register data follows, starting at register 0 and moving up one register per byte. A read always returns register 0 first, then the registers that follow, until the controller refuses a byte. The register values are set only by the power-on reset. Bus traffic alone never restores them.

Top module: `regbank_i2c_slave`

## Requirements
- R1: After reset every register holds RESET_BYTE and SDA is released (`sda_oe_o` = 0).
- R2: The device address is DEV_ADDR (default 7'h69). The address byte is the seven address bits followed by the direction bit (1 = read), so 0xD2 is a write and 0xD3 is a read. The slave acknowledges a matching address by holding SDA low during the ninth SCL pulse.
- R3: If the address does not match, the slave does not acknowledge it. It keeps SDA released and changes no register until the next start condition.
- R4: On a write, the two bytes that follow the address byte are acknowledged and their values are discarded.
- R5: On a write, data bytes after the two filler bytes are stored in register 0, then register 1, and so on, and each one is acknowledged.
- R6: A write byte aimed at an index at or beyond NUM_REGS is acknowledged and leaves every register unchanged.
- R7: A read sends register 0, then register 1, and so on, most significant bit first. The slave moves to the next register only after the controller acknowledges. After a not-acknowledge it releases SDA.
- R8: A read at an index at or beyond NUM_REGS returns 0xFF.
- R9: A repeated start at any point restarts address reception, and register indexing begins again at 0.
- R10: Registers change only through write data bytes. Start and stop conditions on their own, and read traffic, leave them unchanged.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, pull SDA low (open drain) |
| regs_o | output | 8*NUM_REGS | Register contents, register n in bits [8n+7:8n] |

## Verification
The bench builds the block with NUM_REGS = 4 and RESET_BYTE = 0xC3. With only four registers, writes and reads past the last register occur within a few bytes of each transaction. This covers the discarded writes and the 0xFF read-back in both directed and random traffic. The non-default reset byte separates reset values from written zeros and from the 0xFF filler. The default address 0x69 is kept, so the 0xD2 and 0xD3 address bytes are exercised exactly, and random wrong addresses test the ignore path.

// File: rtl/regbank_i2c_pkg.sv
package regbank_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_IGNORE
  } slv_state_e;

  // role of the byte currently being received
  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SKIP0,
    BK_SKIP1,
    BK_DATA
  } byte_kind_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
  import regbank_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  // one extra stage holds the previous synchronised sample
  logic [SYNC_STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_c, scl_p, sda_c, sda_p;
  assign scl_c = scl_sh[SYNC_STAGES-1];
  assign scl_p = scl_sh[SYNC_STAGES];
  assign sda_c = sda_sh[SYNC_STAGES-1];
  assign sda_p = sda_sh[SYNC_STAGES];

  always_comb begin
    evt_o.scl   = scl_c;
    evt_o.sda   = sda_c;
    evt_o.rise  = scl_c & ~scl_p;
    evt_o.fall  = ~scl_c & scl_p;
    evt_o.start = scl_c & scl_p & sda_p & ~sda_c;
    evt_o.stop  = scl_c & scl_p & ~sda_p & sda_c;
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int         NUM_REGS   = 8,
  parameter int         IDX_W      = 4,
  parameter logic [7:0] RESET_BYTE = 8'h5A
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [8*NUM_REGS-1:0] regs_o
);

  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= RESET_BYTE;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) regs_q[g] <= wr_data_i;
    end
    assign regs_o[8*g +: 8] = regs_q[g];
  end

  // past the last register reads as all ones
  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_q[i];
  end

  p_wr_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i < IDX_W'(NUM_REGS)));

  p_regs_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import regbank_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8,
  parameter int         IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_evt_t         evt_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o
);

  slv_state_e       state;
  byte_kind_e       kind;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             ack_drv, rw, mack_ok;
  logic [IDX_W-1:0] idx;

  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] idx_inc;
  assign rx_byte = {shreg[6:0], evt_i.sda};
  // index saturates at NUM_REGS, which means "past the end"
  assign idx_inc = (idx == IDX_W'(NUM_REGS)) ? idx : idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      kind      <= BK_ADDR;
      bit_cnt   <= '0;
      shreg     <= '0;
      ack_drv   <= 1'b0;
      rw        <= 1'b0;
      mack_ok   <= 1'b0;
      idx       <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (evt_i.start) begin
        state   <= ST_RECV;
        kind    <= BK_ADDR;
        bit_cnt <= '0;
        idx     <= '0;
        ack_drv <= 1'b0;
      end else if (evt_i.stop) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
      end else begin
        unique case (state)
          ST_RECV: if (evt_i.rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (kind == BK_ADDR) begin
                if (rx_byte[7:1] == DEV_ADDR) begin
                  rw    <= rx_byte[0];
                  state <= ST_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                state <= ST_ACK;
                if (kind == BK_DATA) begin
                  if (idx < IDX_W'(NUM_REGS)) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= idx;
                    wr_data_o <= rx_byte;
                  end
                  idx <= idx_inc;
                end
              end
            end
          end
          ST_ACK: if (evt_i.fall) begin
            if (!ack_drv) begin
              ack_drv <= 1'b1;
            end else begin
              ack_drv <= 1'b0;
              bit_cnt <= '0;
              if (kind == BK_ADDR && rw) begin
                state <= ST_SEND;
                shreg <= rd_data_i;
              end else begin
                state <= ST_RECV;
                if (kind != BK_DATA) kind <= byte_kind_e'(kind + 2'd1);
              end
            end
          end
          ST_SEND: if (evt_i.fall) begin
            if (bit_cnt == 3'd7) begin
              state <= ST_MACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[6:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (evt_i.rise) begin
              mack_ok <= ~evt_i.sda;
              if (!evt_i.sda) idx <= idx_inc;
            end else if (evt_i.fall) begin
              if (mack_ok) begin
                state   <= ST_SEND;
                shreg   <= rd_data_i;
                bit_cnt <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx_o = idx;
  assign sda_oe_o = (state == ST_ACK && ack_drv) || (state == ST_SEND && !shreg[7]);

  p_sda_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(evt_i.scl));

  p_ack_after_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state == ST_ACK) |-> ($past(evt_i.rise) && $past(bit_cnt) == 3'd7));

  p_tx_msb_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state == ST_SEND) |-> (bit_cnt == 3'd0 && $past(evt_i.fall)));

  p_ignore_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |=> !wr_en_o);

endmodule

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave
  import regbank_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         NUM_REGS   = 8,
  parameter logic [7:0] RESET_BYTE = 8'h5A
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [8*NUM_REGS-1:0] regs_o
);

  localparam int IDX_W = $clog2(NUM_REGS + 1);

  bus_evt_t         evt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_line_cond #(.SYNC_STAGES(2)) u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  i2c_slave_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .rd_data_i(rd_data),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data),
    .rd_idx_o (rd_idx)
  );

  regbank_store #(
    .NUM_REGS  (NUM_REGS),
    .IDX_W     (IDX_W),
    .RESET_BYTE(RESET_BYTE)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );

endmodule

// File: tb/sim_regbank_i2c_slave.sv
module sim_regbank_i2c_slave;
  localparam int         CLK_PERIOD = 10;
  localparam int         NREG       = 4;
  localparam logic [7:0] RST_B      = 8'hC3;
  localparam int         Q          = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [8*NREG-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0, r11_viol = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_i2c_slave #(.DEV_ADDR(7'h69), .NUM_REGS(NREG), .RESET_BYTE(RST_B)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  function automatic logic [7:0] exp_rd(int i);
    return (i < NREG) ? model[i] : 8'hFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    for (int i = 0; i < NREG; i++) chk(tag, 32'(regs[8*i +: 8]), 32'(model[i]));
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  // R11 monitor: slave drive must not change while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && oe_prev !== sda_oe && scl_m) r11_viol++;
    oe_prev <= sda_oe;
  end

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(Q);
      scl_m = 1'b0; hold(1);
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q/2);
    ack = sda_bus;
    hold(Q - Q/2);
    scl_m = 1'b0; hold(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(Q/2);
      b[i] = sda_bus;
      hold(Q - Q/2);
      scl_m = 1'b0;
    end
    hold(1);
    sda_m = mack; hold(Q);
    scl_m = 1'b1; hold(Q);
    scl_m = 1'b0; hold(1);
    sda_m = 1'b1;
  endtask

  // write transaction: address, two filler bytes, n data bytes from wbuf
  task automatic do_write(int n, logic [7:0] f0, logic [7:0] f1);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk("R2 write address ack", 32'(a), 0);
    send_byte(f0, a);    chk("R4 filler0 ack", 32'(a), 0);
    send_byte(f1, a);    chk("R4 filler1 ack", 32'(a), 0);
    chk_regs("R4 fillers discarded");
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(i < NREG ? "R5 data ack" : "R6 past-end ack", 32'(a), 0);
      if (i < NREG) model[i] = wbuf[i];
      chk_regs(i < NREG ? "R5 register load" : "R6 past-end discard");
    end
    bus_stop();
  endtask

  task automatic do_read(int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); chk("R2 read address ack", 32'(a), 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i == n-1));
      chk(i < NREG ? "R7 read order" : "R8 past-end 0xFF", 32'(b), 32'(exp_rd(i)));
    end
    hold(Q);
    chk("R7 release after nack", 32'(sda_oe), 0);
    bus_stop();
    chk_regs("R10 read leaves regs");
  endtask

  task automatic bad_addr(logic [7:0] adr, int n);
    logic a;
    bus_start();
    send_byte(adr, a); chk("R3 wrong address nack", 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(8'(i * 37 + 1), a);
      chk("R3 ignored byte nack", 32'(a), 1);
    end
    bus_stop();
    chk_regs("R3 regs unchanged");
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) model[i] = RST_B;
    hold(4);
    rst_n = 1'b1;
    hold(4);
    // R1
    chk_regs("R1 reset value");
    chk("R1 sda released", 32'(sda_oe), 0);

    // R4/R5: filler values look like data but must be dropped
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    do_write(2, 8'h11, 8'h22);
    // R6: more bytes than registers
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h10 + 8'(i);
    do_write(6, 8'h00, 8'h00);
    // R7/R8
    do_read(6);
    // R3
    bad_addr(8'hA4, 3);
    bad_addr(8'hD0, 2);
    // R10: bare start/stop
    bus_start(); bus_stop();
    chk_regs("R10 start stop only");

    // R9: repeated start after writing reg0, then read from 0 again
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h77, a); model[0] = 8'h77;
    chk("R9 data ack before restart", 32'(a), 0);
    bus_start();
    send_byte(8'hD3, a); chk("R9 restart address ack", 32'(a), 0);
    recv_byte(b, 1'b0); chk("R9 restart reads reg0", 32'(b), 32'h77);
    recv_byte(b, 1'b1); chk("R9 then reg1", 32'(b), 32'(model[1]));
    bus_stop();
    // R9: repeated start in the middle of a filler byte
    bus_start();
    send_byte(8'hD2, a);
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0; hold(1);
    bus_start();
    send_byte(8'hD2, a); chk("R9 mid-byte restart ack", 32'(a), 0);
    send_byte(8'h5E, a); send_byte(8'h5F, a);
    send_byte(8'h3C, a); model[0] = 8'h3C;
    bus_stop();
    chk_regs("R9 restart then write");

    // random traffic
    for (int t = 0; t < 24; t++) begin
      int nw, nr;
      nw = int'($urandom_range(0, 6));
      for (int i = 0; i < nw; i++) wbuf[i] = 8'($urandom);
      do_write(nw, 8'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        b = 8'($urandom);
        if (b[7:1] == 7'h69) b[7:1] = 7'h2A;
        bad_addr(b, int'($urandom_range(0, 3)));
      end
      nr = int'($urandom_range(1, 6));
      do_read(nr);
    end

    chk("R11 drive changes only with SCL low", 32'(r11_viol), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule